// File: doc/BRIEF.md
# Latching Rail Fault Supervisor

This block decides when a multi-rail display supply must shut down. Once the enable input has risen and the power-up sequencer reports that it has finished, the block watches a set of status flags. Four flags report under-voltage on the regulated outputs. One flag reports that the delayed-switch node has been pulled low. Three flags report a reference fault, over-temperature and a fault on the timer node. Until the sequencer reports completion, the block ignores every fault.

Faults fall into two classes. A reference, over-temperature or timer-node fault shuts the supply down at once. An output fault starts a linear timeout count instead. The delayed-switch node counts as an output fault when it is not low. If the output fault clears before the count reaches its terminal value, the count returns to idle and nothing happens. If the count reaches its terminal value, the shutdown output latches high. It stays high until enable is taken low. It is also high after a reset. The timeout length is the parameter `TMO_CYC`, counted in clock cycles; the system sets it to match the nominal 50 ms window. The present count is visible on an output.

Top module: `fault_supervisor`

## Requirements
- R1: During and after reset, with enable low, `shut_o` is 1 and `tmo_cnt_o` is 0.
- R2: While the synchronised enable is low, `shut_o` is 1, the latch is cleared and the count is 0. After enable rises again, `shut_o` returns to 0 on the third rising clock edge after the input change.
- R3: Until `seq_done_i` is 1, every fault input has no effect: `shut_o` stays 0 and `tmo_cnt_o` stays 0.
- R4: During monitoring, a 1 on `ref_flt_i`, `otemp_i` or `tnode_flt_i` sets `shut_o` on the third rising edge after the input change, with no timeout.
- R5: During monitoring, a timed fault makes `tmo_cnt_o` equal k-2 at the k-th rising edge after the fault input is applied. A timed fault is any bit of `uv_i` at 1 (bit i flags output i), or `dsw_low_i` at 0.
- R6: When the count reaches `TMO_CYC`, `shut_o` latches to 1 at that same edge. For a fault held from the start, this is edge `TMO_CYC`+2. The count then holds at `TMO_CYC` and never exceeds it.
- R7: If a timed fault clears before expiry, the count returns to 0 on the third edge after the input clears, and no shutdown occurs. A later timed fault counts again from 0.
- R8: Once `shut_o` has latched, it stays 1 while enable stays high, even after all faults clear.
- R9: A delayed-switch node that is not pulled low (`dsw_low_i` = 0) after sequencing shuts the supply down after the same timeout as an output under-voltage.
- R10: All inputs pass through two synchroniser flops, so no input change affects an output before the third rising edge after that change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Chip enable; low clears the latch |
| seq_done_i | input | 1 | Start-up sequence has completed |
| uv_i | input | NUV | Under-voltage flag for each regulated output |
| dsw_low_i | input | 1 | Delayed-switch node is below its threshold |
| ref_flt_i | input | 1 | Reference fault |
| otemp_i | input | 1 | Over-temperature trip |
| tnode_flt_i | input | 1 | Timer-node fault |
| shut_o | output | 1 | Shutdown request, latched on fault |
| tmo_cnt_o | output | CW | Present timeout count |

## Verification
The timed path is driven in four ways. An under-voltage held to expiry checks the exact expiry edge and the saturation value. An under-voltage dropped at count 13 separates a retriggerable timeout from a cumulative one, and a second fault that then restarts at 0 confirms it. A delayed-switch node left high exercises the inverted-polarity input. Each immediate input is applied separately and sampled on the second and third edges, which separates the immediate path from the timed path and confirms the synchroniser latency. Faults applied before sequencing completes, and faults released after a latch, show the gating by the sequencer and the persistence of the latch.

// File: rtl/fault_supervisor.sv
module fault_supervisor #(
  parameter int NUV     = 4,
  parameter int TMO_CYC = 50000,
  localparam int CW     = $clog2(TMO_CYC + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_i,
  input  logic           seq_done_i,
  input  logic [NUV-1:0] uv_i,
  input  logic           dsw_low_i,
  input  logic           ref_flt_i,
  input  logic           otemp_i,
  input  logic           tnode_flt_i,
  output logic           shut_o,
  output logic [CW-1:0]  tmo_cnt_o
);

  localparam int NIN = NUV + 6;
  localparam logic [CW-1:0] TERM = CW'(TMO_CYC);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

  logic [NIN-1:0] raw, s1, s2;
  logic en_s, done_s, imm, dsw_s;
  logic [NUV-1:0] uv_s;
  logic en_q, armed, lat_q;
  logic [CW-1:0] cnt;
  logic mon, timed, hit;

  assign raw = {en_i, seq_done_i, tnode_flt_i, otemp_i, ref_flt_i, dsw_low_i, uv_i};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
    end

  assign en_s   = s2[NIN-1];
  assign done_s = s2[NIN-2];
  assign imm    = |s2[NUV+3:NUV+1];
  assign dsw_s  = s2[NUV];
  assign uv_s   = s2[NUV-1:0];

  assign mon   = armed & done_s & ~lat_q;
  assign timed = mon & ((|uv_s) | ~dsw_s);
  assign hit   = timed & (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q  <= 1'b0;
      armed <= 1'b0;
      lat_q <= 1'b0;
      cnt   <= '0;
    end else begin
      en_q <= en_s;
      if (!en_s) begin
        armed <= 1'b0;
        lat_q <= 1'b0;
        cnt   <= '0;
      end else begin
        if (!en_q) armed <= 1'b1;
        if (mon && (imm || hit)) lat_q <= 1'b1;
        if (!lat_q) begin
          if (!timed)          cnt <= '0;
          else if (cnt != TERM) cnt <= cnt + 1'b1;
        end
      end
    end

  assign shut_o    = ~en_s | ~armed | lat_q;
  assign tmo_cnt_o = cnt;

endmodule

// File: rtl/fault_supervisor_chk.sv
module fault_supervisor_chk #(
  parameter int TMO_CYC = 50000,
  parameter int CW      = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_s,
  input logic          mon,
  input logic          imm,
  input logic          lat_q,
  input logic          shut_o,
  input logic [CW-1:0] cnt
);

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(TMO_CYC));

  // R2
  en_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> (shut_o && cnt == '0));

  // R8
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q && en_s) |=> (lat_q && shut_o));

  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != $past(cnt)) |-> (cnt == CW'($past(cnt) + 1'b1) || cnt == '0));

  // R4
  latch_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lat_q) |-> ($past(mon) && ($past(imm) || $past(cnt) == CW'(TMO_CYC - 1))));

  // R3
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mon && !lat_q) |=> cnt == '0);

endmodule

bind fault_supervisor fault_supervisor_chk #(.TMO_CYC(TMO_CYC), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_s(en_s), .mon(mon), .imm(imm),
  .lat_q(lat_q), .shut_o(shut_o), .cnt(cnt)
);

// File: tb/fault_supervisor_test.sv
`timescale 1ns/1ps
module fault_supervisor_test;
  localparam int NUV = 4;
  localparam int TMO = 20;
  localparam int CW  = $clog2(TMO + 1);

  logic clk = 0, rst_n = 0, en = 0, done = 0, dsw = 1, rf = 0, ot = 0, tn = 0;
  logic [NUV-1:0] uv = '0;
  logic shut;
  logic [CW-1:0] cnt;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  fault_supervisor #(.NUV(NUV), .TMO_CYC(TMO)) uut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .seq_done_i(done), .uv_i(uv),
    .dsw_low_i(dsw), .ref_flt_i(rf), .otemp_i(ot), .tnode_flt_i(tn),
    .shut_o(shut), .tmo_cnt_o(cnt));

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic t_reset;
    edges(3);
    chk("R1 shut in reset", shut, 1);
    chk("R1 cnt in reset", cnt, 0);
    rst_n = 1;
    edges(3);
    chk("R1 shut after reset", shut, 1);
    chk("R1 cnt after reset", cnt, 0);
  endtask

  task automatic t_enable;
    en = 1;
    edges(2);
    chk("R10 shut before sync", shut, 1);
    edges(1);
    chk("R2 shut after enable", shut, 0);
  endtask

  task automatic t_toggle;
    en = 0;
    edges(4);
    chk("R2 shut en low", shut, 1);
    chk("R2 cnt en low", cnt, 0);
    en = 1;
    edges(4);
    chk("R2 shut re-enabled", shut, 0);
  endtask

  task automatic t_pre_done;
    rf = 1; uv[0] = 1; ot = 1;
    edges(30);
    chk("R3 shut before done", shut, 0);
    chk("R3 cnt before done", cnt, 0);
    rf = 0; uv[0] = 0; ot = 0;
    edges(4);
    done = 1;
    edges(4);
    chk("R3 shut after done", shut, 0);
  endtask

  task automatic t_expire;
    uv[2] = 1;
    edges(12);
    chk("R5 cnt at edge 12", cnt, 10);
    edges(9);
    chk("R6 shut at edge 21", shut, 0);
    chk("R5 cnt at edge 21", cnt, 19);
    edges(1);
    chk("R6 shut at edge 22", shut, 1);
    chk("R6 cnt saturated", cnt, TMO);
    edges(5);
    chk("R6 cnt held", cnt, TMO);
    uv[2] = 0;
    edges(10);
    chk("R8 latch persists", shut, 1);
    t_toggle();
  endtask

  task automatic t_abort;
    uv[1] = 1;
    edges(15);
    chk("R5 cnt at edge 15", cnt, 13);
    uv[1] = 0;
    edges(2);
    chk("R10 cnt before clear seen", cnt, 15);
    edges(1);
    chk("R7 cnt cleared", cnt, 0);
    edges(30);
    chk("R7 no shutdown", shut, 0);
    uv[3] = 1;
    edges(12);
    chk("R7 restart from 0", cnt, 10);
    uv[3] = 0;
    edges(4);
    chk("R7 cleared again", cnt, 0);
    chk("R7 shut after retrigger", shut, 0);
  endtask

  task automatic t_dsw;
    dsw = 0;
    edges(21);
    chk("R9 shut at edge 21", shut, 0);
    edges(1);
    chk("R9 shut at edge 22", shut, 1);
    dsw = 1;
    t_toggle();
  endtask

  task automatic t_imm(input int sel);
    case (sel)
      0: rf = 1;
      1: ot = 1;
      default: tn = 1;
    endcase
    edges(2);
    chk("R4 shut before third edge", shut, 0);
    edges(1);
    chk("R4 immediate shutdown", shut, 1);
    chk("R4 no timeout count", cnt, 0);
    rf = 0; ot = 0; tn = 0;
    edges(4);
    chk("R8 latch after imm", shut, 1);
    t_toggle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_enable();
    t_pre_done();
    t_expire();
    t_abort();
    t_dsw();
    for (int i = 0; i < 3; i++) t_imm(i);
    report();
  end
endmodule